// File: doc/BRIEF.md
# Translation permission and fault checker

This block sits directly behind a translation lookaside buffer. Each cycle in
which the request strobe is high, it takes the lookup outcome (hit flag and the
fields of the matched entry), the page offset of the virtual address, the access
direction, the current two-bit processor mode and an instruction/data select. One
clock later it presents the physical address, a fault strobe, a fault kind and a
four-bit memory-management status vector. The surrounding pipeline uses these
to either forward the access or hand it to the fault logic.

The checks follow a fixed priority. A lookup miss is reported first. After that
comes the per-mode permission mask test, and then the fault-on-access bit. On the
data side the direction selects either the write mask and fault-on-write bit, or
the read mask and fault-on-read bit. Instruction fetches test only the read mask
and also clear the two low bits of the page offset. The flow of the output stage is a two-state
machine. PH_IDLE moves to PH_RESP when the request strobe is high. PH_RESP stays
in PH_RESP on a further request and drops back to PH_IDLE when none comes. The
response strobe is high exactly in PH_RESP.

Top module: `tpc_xlate_check`

## Requirements
- R1: The response strobe `rsp_valid` is high in the cycle that follows a cycle with `req_valid` high, and low in the cycle that follows a cycle with `req_valid` low.
- R2: When `req_valid` is low, the other inputs are ignored. In the next cycle `rsp_fault` is 0, `rsp_kind` is 0, `rsp_status` is 0 and `rsp_paddr` is 0.
- R3: On a data-side hit, `rsp_paddr` is the entry page number shifted left by 13 with the 13-bit virtual page offset in the low bits. This holds even when a permission fault is reported.
- R4: On an instruction-side hit, bits 1:0 of `rsp_paddr` are 0 and the other offset bits come from the virtual offset.
- R5: A miss (`req_hit`=0) has priority over every other check. It gives `rsp_kind`=1 (miss) and `rsp_paddr`=0. The status is bit 0 (write) alone for a data write, and 0 for a data read or any fetch.
- R6: On a data write hit with write-mask bit [mode] clear, `rsp_kind`=2 (violation). The status holds bit 0 and bit 1, plus bit 3 when the entry's fault-on-write bit is set.
- R7: On a data write hit that passes the mask with fault-on-write set, `rsp_kind`=3 (fault-on-access). The status holds exactly bits 0 and 3.
- R8: On a data read hit with read-mask bit [mode] clear, `rsp_kind`=2. The status holds bit 1, plus bit 2 when the entry's fault-on-read bit is set.
- R9: On a data read hit that passes the mask with fault-on-read set, `rsp_kind`=3. The status holds exactly bit 2.
- R10: On a fetch hit, only read-mask bit [mode] is tested. When it is clear, `rsp_kind`=2 and the status is exactly bit 1. The write flag, the write mask and both fault-on bits have no effect on a fetch.
- R11: When no check fails, `rsp_kind`=0, `rsp_status`=0 and `rsp_fault`=0. `rsp_fault` is 1 exactly when `rsp_kind` is nonzero.
- R12: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_hit | input | 1 | TLB lookup hit |
| req_ppn | input | 21 | Physical page number of the matched entry |
| req_rd_mask | input | 4 | Read permission, one bit per mode |
| req_wr_mask | input | 4 | Write permission, one bit per mode |
| req_fo_rd | input | 1 | Entry fault-on-read bit |
| req_fo_wr | input | 1 | Entry fault-on-write bit |
| req_va_off | input | 13 | Page offset of the virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Current processor mode |
| req_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 34 | Physical address |
| rsp_fault | output | 1 | Fault reported |
| rsp_kind | output | 2 | 0 none, 1 miss, 2 violation, 3 fault-on-access |
| rsp_status | output | 4 | bit0 write, bit1 violation, bit2 fault-on-read, bit3 fault-on-write |

## Verification
A permission violation and a fault-on-access bit can apply to the same entry in the same access. In that case the violation must win the kind, while the status must still carry the fault-on flag. The bench provokes this with directed entries whose mask bit for the current mode is clear and whose fault-on bit is set, on both directions. It also uses random entries in which both conditions often occur together. Each response is judged against a bench function. That function computes the kind, the status and the address directly from the check order.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_MISS = 2'd1,
        FK_ACV  = 2'd2,
        FK_FOE  = 2'd3
    } fault_kind_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RESP = 1'b1
    } phase_e;

    localparam int STAT_W   = 4;
    localparam int STAT_WR  = 0;
    localparam int STAT_ACV = 1;
    localparam int STAT_FOR = 2;
    localparam int STAT_FOW = 3;

endpackage

// File: rtl/tpc_mode_decode.sv
module tpc_mode_decode #(
    parameter int MODE_W = 2,
    localparam int MODES = 1 << MODE_W
) (
    input  logic [MODE_W-1:0] mode,
    output logic [MODES-1:0]  onehot
);
    for (genvar g = 0; g < MODES; g++) begin : g_dec
        assign onehot[g] = (mode == g[MODE_W-1:0]);
    end
endmodule

// File: rtl/tpc_addr_form.sv
module tpc_addr_form #(
    parameter int PA_W       = 34,
    parameter int PAGE_SHIFT = 13,
    localparam int PPN_W     = PA_W - PAGE_SHIFT
) (
    input  logic                  hit,
    input  logic                  ifetch,
    input  logic [PPN_W-1:0]      ppn,
    input  logic [PAGE_SHIFT-1:0] va_off,
    output logic [PA_W-1:0]       paddr
);
    logic [PAGE_SHIFT-1:0] off_adj;

    always_comb begin
        off_adj = va_off;
        if (ifetch) begin
            off_adj[1:0] = 2'b00;
        end
        paddr = hit ? {ppn, off_adj} : '0;
    end
endmodule

// File: rtl/tpc_perm_eval.sv
module tpc_perm_eval
    import tpc_pkg::*;
#(
    parameter int MODE_W = 2,
    localparam int MODES = 1 << MODE_W
) (
    input  logic              hit,
    input  logic              ifetch,
    input  logic              write,
    input  logic [MODES-1:0]  mode_sel,
    input  logic [MODES-1:0]  rd_mask,
    input  logic [MODES-1:0]  wr_mask,
    input  logic              fo_rd,
    input  logic              fo_wr,
    output fault_kind_e       kind,
    output logic [STAT_W-1:0] status
);
    logic rd_ok;
    logic wr_ok;

    assign rd_ok = |(rd_mask & mode_sel);
    assign wr_ok = |(wr_mask & mode_sel);

    always_comb begin
        kind   = FK_NONE;
        status = '0;
        if (!hit) begin
            kind = FK_MISS;
            status[STAT_WR] = write && !ifetch;
        end else if (ifetch) begin
            if (!rd_ok) begin
                kind = FK_ACV;
                status[STAT_ACV] = 1'b1;
            end
        end else if (write) begin
            if (!wr_ok) begin
                kind = FK_ACV;
                status[STAT_WR]  = 1'b1;
                status[STAT_ACV] = 1'b1;
                status[STAT_FOW] = fo_wr;
            end else if (fo_wr) begin
                kind = FK_FOE;
                status[STAT_WR]  = 1'b1;
                status[STAT_FOW] = 1'b1;
            end
        end else begin
            if (!rd_ok) begin
                kind = FK_ACV;
                status[STAT_ACV] = 1'b1;
                status[STAT_FOR] = fo_rd;
            end else if (fo_rd) begin
                kind = FK_FOE;
                status[STAT_FOR] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tpc_xlate_check.sv
module tpc_xlate_check
    import tpc_pkg::*;
#(
    parameter int PA_W       = 34,
    parameter int PAGE_SHIFT = 13,
    parameter int MODE_W     = 2,
    localparam int PPN_W     = PA_W - PAGE_SHIFT,
    localparam int MODES     = 1 << MODE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_hit,
    input  logic [PPN_W-1:0]      req_ppn,
    input  logic [MODES-1:0]      req_rd_mask,
    input  logic [MODES-1:0]      req_wr_mask,
    input  logic                  req_fo_rd,
    input  logic                  req_fo_wr,
    input  logic [PAGE_SHIFT-1:0] req_va_off,
    input  logic                  req_write,
    input  logic [MODE_W-1:0]     req_mode,
    input  logic                  req_ifetch,
    output logic                  rsp_valid,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  rsp_fault,
    output logic [1:0]            rsp_kind,
    output logic [STAT_W-1:0]     rsp_status
);
    phase_e            phase_q;
    phase_e            phase_d;
    logic [MODES-1:0]  mode_sel;
    logic [PA_W-1:0]   paddr_c;
    fault_kind_e       kind_c;
    logic [STAT_W-1:0] status_c;

    tpc_mode_decode #(.MODE_W(MODE_W)) u_dec (
        .mode   (req_mode),
        .onehot (mode_sel)
    );

    tpc_addr_form #(.PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_addr (
        .hit    (req_hit),
        .ifetch (req_ifetch),
        .ppn    (req_ppn),
        .va_off (req_va_off),
        .paddr  (paddr_c)
    );

    tpc_perm_eval #(.MODE_W(MODE_W)) u_perm (
        .hit      (req_hit),
        .ifetch   (req_ifetch),
        .write    (req_write),
        .mode_sel (mode_sel),
        .rd_mask  (req_rd_mask),
        .wr_mask  (req_wr_mask),
        .fo_rd    (req_fo_rd),
        .fo_wr    (req_fo_wr),
        .kind     (kind_c),
        .status   (status_c)
    );

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: phase_d = req_valid ? PH_RESP : PH_IDLE;
            PH_RESP: phase_d = req_valid ? PH_RESP : PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_paddr  <= '0;
            rsp_fault  <= 1'b0;
            rsp_kind   <= FK_NONE;
            rsp_status <= '0;
        end else begin
            rsp_paddr  <= paddr_c;
            rsp_fault  <= (kind_c != FK_NONE);
            rsp_kind   <= kind_c;
            rsp_status <= status_c;
        end
    end

    assign rsp_valid = (phase_q == PH_RESP);

endmodule

// File: rtl/tpc_xlate_check_sva.sv
module tpc_xlate_check_sva
    import tpc_pkg::*;
#(
    parameter int PA_W       = 34,
    parameter int PAGE_SHIFT = 13,
    parameter int MODE_W     = 2,
    localparam int PPN_W     = PA_W - PAGE_SHIFT,
    localparam int MODES     = 1 << MODE_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_hit,
    input logic [PPN_W-1:0]      req_ppn,
    input logic                  req_write,
    input logic                  req_ifetch,
    input logic                  rsp_valid,
    input logic [PA_W-1:0]       rsp_paddr,
    input logic                  rsp_fault,
    input logic [1:0]            rsp_kind,
    input logic [STAT_W-1:0]     rsp_status
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_status == '0));

    a_r4_fetch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ifetch) |=> (rsp_paddr[1:0] == 2'b00));

    a_r5_miss_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hit) |=> (rsp_kind == FK_MISS && rsp_paddr == '0));

    a_r3_ppn_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hit) |=> (rsp_paddr[PA_W-1:PAGE_SHIFT] == $past(req_ppn)));

    a_r7_foe_no_acv: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_kind == FK_FOE) |-> !rsp_status[STAT_ACV]);

    a_r10_fetch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_ifetch || !req_write)) |=> !rsp_status[STAT_WR]);

    a_r11_fault_matches_kind: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault == (rsp_kind != FK_NONE));

    a_r11_status_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_status != '0) |-> rsp_fault);
endmodule

bind tpc_xlate_check tpc_xlate_check_sva #(
    .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .MODE_W(MODE_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_hit    (req_hit),
    .req_ppn    (req_ppn),
    .req_write  (req_write),
    .req_ifetch (req_ifetch),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .rsp_kind   (rsp_kind),
    .rsp_status (rsp_status)
);

// File: tb/tb_tpc_xlate_check.sv
`timescale 1ns/1ps
module tb_tpc_xlate_check;
    localparam int PA_W  = 34;
    localparam int PS    = 13;
    localparam int PPN_W = PA_W - PS;
    localparam int RW    = 1 + PA_W + 1 + 2 + 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_hit = 1'b0;
    logic [PPN_W-1:0] req_ppn = '0;
    logic [3:0]      req_rd_mask = '0;
    logic [3:0]      req_wr_mask = '0;
    logic            req_fo_rd = 1'b0;
    logic            req_fo_wr = 1'b0;
    logic [PS-1:0]   req_va_off = '0;
    logic            req_write = 1'b0;
    logic [1:0]      req_mode = '0;
    logic            req_ifetch = 1'b0;
    logic            rsp_valid;
    logic [PA_W-1:0] rsp_paddr;
    logic            rsp_fault;
    logic [1:0]      rsp_kind;
    logic [3:0]      rsp_status;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tpc_xlate_check dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
        .req_ppn(req_ppn), .req_rd_mask(req_rd_mask), .req_wr_mask(req_wr_mask),
        .req_fo_rd(req_fo_rd), .req_fo_wr(req_fo_wr), .req_va_off(req_va_off),
        .req_write(req_write), .req_mode(req_mode), .req_ifetch(req_ifetch),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_kind(rsp_kind), .rsp_status(rsp_status)
    );

    // Expected response {valid, paddr, fault, kind, status} from the check order.
    function automatic logic [RW-1:0] model(input logic v);
        logic [PA_W-1:0] pa;
        logic [1:0] k;
        logic [3:0] s;
        logic [PS-1:0] off;
        logic rok, wok;
        pa = '0; k = 2'd0; s = 4'd0;
        if (!v) return '0;
        rok = req_rd_mask[req_mode];
        wok = req_wr_mask[req_mode];
        off = req_va_off;
        if (req_ifetch) off = off & ~13'd3;
        if (!req_hit) begin
            k = 2'd1;
            if (req_write && !req_ifetch) s = 4'b0001;
        end else begin
            pa = {req_ppn, off};
            if (req_ifetch) begin
                if (!rok) begin k = 2'd2; s = 4'b0010; end
            end else if (req_write) begin
                if (!wok) begin k = 2'd2; s = req_fo_wr ? 4'b1011 : 4'b0011; end
                else if (req_fo_wr) begin k = 2'd3; s = 4'b1001; end
            end else begin
                if (!rok) begin k = 2'd2; s = req_fo_rd ? 4'b0110 : 4'b0010; end
                else if (req_fo_rd) begin k = 2'd3; s = 4'b0100; end
            end
        end
        return {1'b1, pa, (k != 2'd0), k, s};
    endfunction

    task automatic check(input string tag, input logic [RW-1:0] exp);
        logic [RW-1:0] got;
        got = {rsp_valid, rsp_paddr, rsp_fault, rsp_kind, rsp_status};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic h, input logic [PPN_W-1:0] p,
                         input logic [3:0] rm, input logic [3:0] wm,
                         input logic fr, input logic fw, input logic [PS-1:0] o,
                         input logic w, input logic [1:0] m, input logic f);
        req_valid = v; req_hit = h; req_ppn = p; req_rd_mask = rm; req_wr_mask = wm;
        req_fo_rd = fr; req_fo_wr = fw; req_va_off = o; req_write = w;
        req_mode = m; req_ifetch = f;
    endtask

    // Drive at a falling edge, check at the next falling edge.
    task automatic xact(input string tag, input logic v, input logic h,
                        input logic [PPN_W-1:0] p, input logic [3:0] rm,
                        input logic [3:0] wm, input logic fr, input logic fw,
                        input logic [PS-1:0] o, input logic w, input logic [1:0] m,
                        input logic f);
        logic [RW-1:0] e;
        @(negedge clk);
        drive(v, h, p, rm, wm, fr, fw, o, w, m, f);
        e = model(v);
        @(negedge clk);
        check(tag, e);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        string t;
        r = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        check("R12 reset", '0);
        rst_n = 1'b1;

        xact("R3 data read ok", 1, 1, 21'h1ABCDE, 4'hF, 4'hF, 0, 0, 13'h1FFF, 0, 2'd2, 0);
        xact("R3 data write ok", 1, 1, 21'h000001, 4'h0, 4'h8, 0, 0, 13'h0003, 1, 2'd3, 0);
        xact("R4 fetch aligned", 1, 1, 21'h0F0F0F, 4'h1, 4'h0, 0, 0, 13'h1237, 0, 2'd0, 1);
        xact("R5 miss write", 1, 0, 21'h1FFFFF, 4'h0, 4'h0, 1, 1, 13'h0AAA, 1, 2'd1, 0);
        xact("R5 miss read", 1, 0, 21'h1FFFFF, 4'hF, 4'hF, 1, 1, 13'h0AAA, 0, 2'd1, 0);
        xact("R5 R10 fetch miss", 1, 0, 21'h0, 4'hF, 4'hF, 0, 0, 13'h0005, 1, 2'd0, 1);
        xact("R6 write acv with fow", 1, 1, 21'h00ABC, 4'hF, 4'hB, 0, 1, 13'h0100, 1, 2'd2, 0);
        xact("R6 write acv", 1, 1, 21'h00ABC, 4'hF, 4'h0, 1, 0, 13'h0100, 1, 2'd0, 0);
        xact("R7 write fow", 1, 1, 21'h12345, 4'h0, 4'h2, 1, 1, 13'h0010, 1, 2'd1, 0);
        xact("R8 read acv with for", 1, 1, 21'h54321, 4'h7, 4'hF, 1, 1, 13'h1000, 0, 2'd3, 0);
        xact("R8 read acv", 1, 1, 21'h54321, 4'hE, 4'hF, 0, 1, 13'h1000, 0, 2'd0, 0);
        xact("R9 read for", 1, 1, 21'h00077, 4'h4, 4'h0, 1, 1, 13'h0777, 0, 2'd2, 0);
        xact("R10 fetch acv ignores fo and write", 1, 1, 21'h0CAFE, 4'hD, 4'hF, 1, 1, 13'h0FFF, 1, 2'd1, 1);
        xact("R10 fetch pass ignores fo", 1, 1, 21'h0CAFE, 4'h2, 4'h0, 1, 1, 13'h0FFE, 1, 2'd1, 1);
        xact("R11 no fault", 1, 1, 21'h1FFFFF, 4'h1, 4'h1, 0, 0, 13'h0000, 1, 2'd0, 0);
        xact("R2 idle ignores miss", 0, 0, 21'h1FFFFF, 4'h0, 4'h0, 1, 1, 13'h1FFF, 1, 2'd3, 0);
        xact("R1 restart after idle", 1, 1, 21'h00002, 4'hF, 4'hF, 0, 0, 13'h0004, 0, 2'd1, 0);

        for (int i = 0; i < 400; i++) begin
            logic v, h, fr, fw, w, f;
            logic [PPN_W-1:0] p;
            logic [3:0] rm, wm;
            logic [PS-1:0] o;
            logic [1:0] m;
            r = $urandom; v = (r[3:0] != 4'd0); h = (r[6:4] != 3'd0);
            fr = r[7]; fw = r[8]; w = r[9]; f = (r[11:10] == 2'd0);
            m = r[13:12]; rm = r[17:14]; wm = r[21:18];
            r = $urandom; p = r[PPN_W-1:0];
            r = $urandom; o = r[PS-1:0];
            if (!v) t = "R2 random idle";
            else if (!h) t = "R5 random miss";
            else if (f) t = "R10 random fetch";
            else if (w) t = "R6 R7 random write";
            else t = "R8 R9 random read";
            xact(t, v, h, p, rm, wm, fr, fw, o, w, m, f);
        end

        @(negedge clk);
        drive(0, 0, '0, '0, '0, 0, 0, '0, 0, 2'd0, 0);
        @(negedge clk);
        check("R1 R2 final idle", '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule